// File: doc/BRIEF.md
# Pin Interrupt and Wake Status Logic

This block holds the interrupt and wake configuration of a single general-purpose pin. It watches the already filtered pin level and latches an interrupt status bit and a wake status bit. It also drives a request line toward a chip-level interrupt aggregator. Software configures it through a one-word write port, and a readback word shows the configuration, both status bits, the output-drive settings and the live pin level.

The pin can be sensed by level or by edge. A polarity field selects high or rising, low or falling, or both edges. An enable bit decides whether interrupt status is captured at all. A separate mask bit decides whether captured status reaches the request line. Wake arming is held once per sleep state. The current sleep state is given as a small code, and wake status is captured only when the trigger condition occurs while the enable bit for that state is set.

Top module: `pin_irq_wake`

## Requirements
- R1: After reset, the readback word, both status bits and the request line are 0, apart from the live pin level in bit 13.
- R2: With bit 0 set to 1 (level sensing), polarity code 0 sets interrupt status while the pin is high, and code 1 sets it while the pin is low. Status written clear with 1 stays 1 while the active level persists. It clears once the level has gone.
- R3: With bit 0 set to 0 (edge sensing), polarity code 0 sets status on a 0-to-1 pin transition and code 1 on a 1-to-0 transition. Edges are found by comparing the pin with its value one cycle earlier. A steady level, or the opposite edge, sets nothing.
- R4: In edge sensing, polarity code 2 sets status on both transitions.
- R5: In level sensing, polarity codes 2 and 3 never set status. In edge sensing, code 3 never sets status.
- R6: Interrupt status is captured only while the enable bit (bit 3) is 1. Clearing the enable bit keeps status that is already set.
- R7: The request line is high exactly when interrupt status is 1 and the mask bit (bit 4) is 1.
- R8: Writing 1 to bit 9 clears interrupt status and writing 1 to bit 10 clears wake status. Writing 0 to either bit leaves it unchanged, and a write never sets them.
- R9: Sleep-state codes 1 to 4 select wake-enable bits 5 to 8 in that order. Wake status (bit 10) is set when a trigger condition occurs while the enable for the current state is 1, whatever the interrupt enable is. Codes 0 and 5 to 7 never set wake status.
- R10: When a clearing write and a new trigger event fall in the same cycle, the status bit ends up set.
- R11: The readback word carries output enable in bit 11 and output value in bit 12, both read/write. It carries the live pin level in bit 13, and the polarity field in bits 2:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | REG_W | Write data: configuration fields and write-1-to-clear status bits |
| rd_data | output | REG_W | Readback word |
| pin_in | input | 1 | Filtered pin level |
| sleep_state | input | SLEEP_W | Current sleep-state code |
| irq_status | output | 1 | Latched interrupt status |
| wake_status | output | 1 | Latched wake status |
| irq_req | output | 1 | Masked interrupt request toward the aggregator |

## Verification
The assertions assume that `pin_in` and `sleep_state` are synchronous to `clk`. They also assume that the pin's value during reset is a legal previous sample for edge detection. The stimulus changes every input only on the falling clock edge, and it holds the pin low through reset. Before a new sensing mode is tested, the configuration is written first and the status bits are cleared in a second write. This keeps the trigger built from the old configuration away from the checks of the new one.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

   // field positions of the per-pin word
   localparam int F_LVL     = 0;
   localparam int F_POL     = 1;
   localparam int POL_W     = 2;
   localparam int F_EN      = 3;
   localparam int F_MSK     = 4;
   localparam int F_WAKE    = 5;
   localparam int WAKE_MAX  = 4;
   localparam int F_IST     = 9;
   localparam int F_WST     = 10;
   localparam int F_OE      = 11;
   localparam int F_OV      = 12;
   localparam int F_PIN     = 13;
   localparam int REG_MIN_W = F_PIN + 1;

   typedef enum logic [POL_W-1:0] {
      POL_HIGH = 2'b00,
      POL_LOW  = 2'b01,
      POL_BOTH = 2'b10,
      POL_NONE = 2'b11
   } pol_e;

endpackage

// File: rtl/pinirq_trigger.sv
module pinirq_trigger
   import pinirq_pkg::*;
#(
   parameter bit BOTH_EDGES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             level_i,
   input  logic [POL_W-1:0] pol_i,
   output logic             hit_o
);

   logic pin_q;
   logic rise, fall, lvl_hit, edge_hit, both_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_i;
   end

   assign rise = pin_i & ~pin_q;
   assign fall = ~pin_i & pin_q;

   generate
      if (BOTH_EDGES) begin : g_both
         assign both_hit = rise | fall;
      end else begin : g_single
         assign both_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      lvl_hit  = 1'b0;
      edge_hit = 1'b0;
      unique case (pol_e'(pol_i))
         POL_HIGH: begin lvl_hit = pin_i;  edge_hit = rise; end
         POL_LOW:  begin lvl_hit = ~pin_i; edge_hit = fall; end
         POL_BOTH: begin lvl_hit = 1'b0;   edge_hit = both_hit; end
         default:  begin lvl_hit = 1'b0;   edge_hit = 1'b0; end
      endcase
   end

   assign hit_o = level_i ? lvl_hit : edge_hit;

   AST_NO_BOTH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i && pol_i[1]) |-> !hit_o);                                // R5
   AST_RISE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && pol_i == POL_HIGH && $rose(pin_i)) |-> hit_o);       // R3
   AST_LEVEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (level_i && pol_i == POL_LOW && !pin_i) |-> hit_o);               // R2

endmodule

// File: rtl/pinirq_stsbit.sv
module pinirq_stsbit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);                                                   // R10
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);                                      // R8
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));                             // R8

endmodule

// File: rtl/pinirq_wakesel.sv
module pinirq_wakesel #(
   parameter int SLEEP_W  = 3,
   parameter int NUM_WAKE = 4
) (
   input  logic [SLEEP_W-1:0]  state_i,
   input  logic [NUM_WAKE-1:0] en_i,
   output logic                arm_o
);

   logic [NUM_WAKE-1:0] sel;

   generate
      for (genvar k = 0; k < NUM_WAKE; k++) begin : g_state
         assign sel[k] = en_i[k] && (state_i == SLEEP_W'(k + 1));
      end
   endgenerate

   assign arm_o = |sel;

endmodule

// File: rtl/pin_irq_wake.sv
module pin_irq_wake
   import pinirq_pkg::*;
#(
   parameter int REG_W      = 16,
   parameter int SLEEP_W    = 3,
   parameter int NUM_WAKE   = 4,
   parameter bit BOTH_EDGES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   input  logic               pin_in,
   input  logic [SLEEP_W-1:0] sleep_state,
   output logic               irq_status,
   output logic               wake_status,
   output logic               irq_req
);

   localparam int SPARE_W = REG_W - F_PIN;

   generate
      if (REG_W < REG_MIN_W) begin : g_bad_width
         $error("REG_W too small for the field layout");
      end
      if (NUM_WAKE < 1 || NUM_WAKE > WAKE_MAX) begin : g_bad_wake
         $error("NUM_WAKE out of range");
      end
      if ((1 << SLEEP_W) <= NUM_WAKE) begin : g_bad_sleep
         $error("SLEEP_W cannot encode every wake state");
      end
   endgenerate

   logic                lvl_q, en_q, msk_q, oe_q, ov_q;
   logic [POL_W-1:0]    pol_q;
   logic [NUM_WAKE-1:0] wen_q;
   logic                hit, wake_arm;
   logic                unused_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         pol_q <= POL_HIGH;
         en_q  <= 1'b0;
         msk_q <= 1'b0;
         wen_q <= '0;
         oe_q  <= 1'b0;
         ov_q  <= 1'b0;
      end else if (wr_en) begin
         lvl_q <= wr_data[F_LVL];
         pol_q <= wr_data[F_POL +: POL_W];
         en_q  <= wr_data[F_EN];
         msk_q <= wr_data[F_MSK];
         wen_q <= wr_data[F_WAKE +: NUM_WAKE];
         oe_q  <= wr_data[F_OE];
         ov_q  <= wr_data[F_OV];
      end
   end

   assign unused_wr = ^wr_data[REG_W-1 -: SPARE_W];

   pinirq_trigger #(.BOTH_EDGES(BOTH_EDGES)) i_trigger (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_in),
      .level_i (lvl_q),
      .pol_i   (pol_q),
      .hit_o   (hit)
   );

   pinirq_wakesel #(.SLEEP_W(SLEEP_W), .NUM_WAKE(NUM_WAKE)) i_wakesel (
      .state_i (sleep_state),
      .en_i    (wen_q),
      .arm_o   (wake_arm)
   );

   pinirq_stsbit i_irq_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit & en_q),
      .clr_i (wr_en & wr_data[F_IST]),
      .q_o   (irq_status)
   );

   pinirq_stsbit i_wake_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit & wake_arm),
      .clr_i (wr_en & wr_data[F_WST]),
      .q_o   (wake_status)
   );

   assign irq_req = irq_status & msk_q;

   always_comb begin
      rd_data                   = '0;
      rd_data[F_LVL]            = lvl_q;
      rd_data[F_POL +: POL_W]   = pol_q;
      rd_data[F_EN]             = en_q;
      rd_data[F_MSK]            = msk_q;
      rd_data[F_WAKE +: NUM_WAKE] = wen_q;
      rd_data[F_IST]            = irq_status;
      rd_data[F_WST]            = wake_status;
      rd_data[F_OE]             = oe_q;
      rd_data[F_OV]             = ov_q;
      rd_data[F_PIN]            = pin_in;
   end

   AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status && !irq_req) |-> !rd_data[F_MSK]);                    // R7
   AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !irq_status) |=> !irq_status);                          // R6
   AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_arm && !wake_status) |=> !wake_status);                    // R9
   AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_state == '0) |-> !wake_arm);                               // R9

endmodule

// File: tb/test_pin_irq_wake.sv
`timescale 1ns/1ps
module test_pin_irq_wake;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        pin_in = 1'b0;
   logic [2:0]  sleep_state = 3'd0;
   logic        irq_status, wake_status, irq_req;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pin_irq_wake i_pin_irq_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .pin_in      (pin_in),
      .sleep_state (sleep_state),
      .irq_status  (irq_status),
      .wake_status (wake_status),
      .irq_req     (irq_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // configure, then clear both status bits in a second write
   task automatic setup(input logic [15:0] cfg);
      wr(cfg);
      wr(cfg | 16'h0600);
   endtask

   task automatic t_reset;
      chk("R1 readback", rd_data, 16'h0000);
      chk("R1 irq_status", irq_status, 0);
      chk("R1 wake_status", wake_status, 0);
      chk("R1 irq_req", irq_req, 0);
   endtask

   task automatic t_rise;
      setup(16'h0018);
      set_pin(1);
      chk("R3 rising sets", irq_status, 1);
      chk("R7 req unmasked", irq_req, 1);
      wr(16'h0218);
      chk("R8 w1c clears", irq_status, 0);
      idle(3);
      chk("R3 steady high no set", irq_status, 0);
      set_pin(0);
      chk("R3 falling ignored", irq_status, 0);
   endtask

   task automatic t_fall;
      setup(16'h001A);
      set_pin(1);
      chk("R3 rising ignored in falling mode", irq_status, 0);
      set_pin(0);
      chk("R3 falling sets", irq_status, 1);
      wr(16'h021A);
      chk("R8 w1c clears", irq_status, 0);
   endtask

   task automatic t_both;
      setup(16'h001C);
      set_pin(1);
      chk("R4 both rising", irq_status, 1);
      wr(16'h021C);
      set_pin(0);
      chk("R4 both falling", irq_status, 1);
      wr(16'h021C);
      chk("R4 cleared", irq_status, 0);
   endtask

   task automatic t_level;
      setup(16'h0019);
      chk("R2 level high idle", irq_status, 0);
      set_pin(1);
      chk("R2 level high sets", irq_status, 1);
      wr(16'h0219);
      chk("R2 persists through clear", irq_status, 1);
      set_pin(0);
      wr(16'h0219);
      chk("R2 clears after level gone", irq_status, 0);
      wr(16'h001B);
      idle(1);
      chk("R2 level low sets", irq_status, 1);
      set_pin(1);
      wr(16'h021B);
      chk("R2 level low cleared", irq_status, 0);
      set_pin(0);
      wr(16'h0018);
      wr(16'h0618);
   endtask

   task automatic t_level_both;
      setup(16'h001D);
      set_pin(1);
      set_pin(0);
      chk("R5 code 2 in level mode", irq_status, 0);
      setup(16'h001F);
      set_pin(1);
      set_pin(0);
      chk("R5 code 3 in level mode", irq_status, 0);
      setup(16'h001E);
      set_pin(1);
      set_pin(0);
      chk("R5 code 3 in edge mode", irq_status, 0);
   endtask

   task automatic t_enable;
      setup(16'h0010);
      set_pin(1);
      chk("R6 disabled no capture", irq_status, 0);
      set_pin(0);
      wr(16'h0018);
      set_pin(1);
      chk("R6 enabled capture", irq_status, 1);
      wr(16'h0010);
      chk("R6 status kept after disable", irq_status, 1);
      set_pin(0);
      wr(16'h0610);
   endtask

   task automatic t_mask;
      setup(16'h0008);
      set_pin(1);
      chk("R7 status set while masked", irq_status, 1);
      chk("R7 masked no req", irq_req, 0);
      wr(16'h0018);
      chk("R7 unmask forwards", irq_req, 1);
      chk("R8 write 0 keeps status", irq_status, 1);
      set_pin(0);
      wr(16'h0618);
      chk("R7 req drops with status", irq_req, 0);
   endtask

   task automatic t_wake;
      sleep_state = 3'd2;
      setup(16'h0040);
      set_pin(1);
      chk("R9 wake in state 2", wake_status, 1);
      chk("R9 no irq without enable", irq_status, 0);
      set_pin(0);
      wr(16'h0440);
      chk("R8 wake w1c", wake_status, 0);
      sleep_state = 3'd3;
      set_pin(1);
      chk("R9 state 3 not armed", wake_status, 0);
      set_pin(0);
      wr(16'h01E0);
      sleep_state = 3'd5;
      set_pin(1);
      chk("R9 state 5 never wakes", wake_status, 0);
      set_pin(0);
      sleep_state = 3'd0;
      set_pin(1);
      chk("R9 state 0 never wakes", wake_status, 0);
      set_pin(0);
      sleep_state = 3'd4;
      set_pin(1);
      chk("R9 wake in state 4", wake_status, 1);
      set_pin(0);
      wr(16'h05E0);
      chk("R8 wake cleared", wake_status, 0);
      sleep_state = 3'd1;
      wr(16'h0020);
      set_pin(1);
      chk("R9 wake in state 1", wake_status, 1);
      set_pin(0);
      wr(16'h0420);
      sleep_state = 3'd0;
   endtask

   task automatic t_collide;
      setup(16'h0018);
      @(negedge clk);
      pin_in  = 1'b1;
      wr_en   = 1'b1;
      wr_data = 16'h0218;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
      chk("R10 set wins over clear", irq_status, 1);
   endtask

   task automatic t_readback;
      wr(16'h1818);
      chk("R11 readback with pin high", rd_data, 16'h3A18);
      set_pin(0);
      wr(16'h1A18);
      chk("R11 readback pin low", rd_data, 16'h1818);
      wr(16'h0806);
      chk("R11 oe and polarity", rd_data, 16'h0806);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_rise;
      t_fall;
      t_both;
      t_level;
      t_level_both;
      t_enable;
      t_mask;
      t_wake;
      t_collide;
      t_readback;
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule